// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block sits between a queue of command words and the bit-level engine of an I2C master. It reads the head of the command queue and turns each word into one byte-level request to the engine: a START with an address byte, a data byte to send, a byte to receive, or a STOP. The engine confirms each request with a done pulse, and then the sequencer decides the next step. A receive command asks for a run of bytes. The sequencer counts that run by itself and chooses ACK or NACK for every byte. For the last byte of the run it checks whether the next queued word also asks for received data.

When no further work can go out, the sequencer either raises a stall flag or closes the transfer with a STOP. A stall tells the engine to hold the clock low before the first bit of the next byte. Which of the two happens depends on the master enable, the auto-stop enable, the command queue level and the receive buffer level. A START word also picks one of two timing sets, and that choice lasts until the next START.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command word is 11 bits wide. Bits [10:8] hold the opcode and bits [7:0] hold the payload. The opcodes are:
  - 0: send the payload byte.
  - 1: receive payload+1 bytes and keep them.
  - 2: receive payload+1 bytes and throw them away.
  - 3: START with the payload as the address byte.
  - 4: START with the address byte, using the alternate timing set.
  - 5: STOP.
  - 6 and 7: while busy, these are popped and produce no request.
- R2: Each request to the engine uses fixed `eng_op` codes: 1 START, 2 send, 3 receive, 4 STOP.
  - `eng_data` carries the payload for START and send, and is 0 otherwise.
  - `eng_req` stays high, with `eng_op`, `eng_data` and `eng_ack` unchanged, until `eng_done` is sampled.
  - A receive word is popped once and produces exactly payload+1 receive requests.
- R3: For a receive request that is not the last byte of its command, `eng_ack` is 1. For the last byte, `eng_ack` is 1 only if the queue is not empty and its head opcode is 1 or 2; otherwise it is 0. For any request other than receive, `eng_ack` is 0.
- R4: `rx_store` is 1 on a receive request only when the command opcode is 1 and `rx_discard_match` is low. In every other case it is 0.
- R5: On every START request, `eng_alt` is set: 1 for opcode 4 and 0 for opcode 3. It keeps that value through the following requests until the next START.
- R6: If the block is busy, enabled, with auto-stop off and an empty queue, `stall` is 1. In that state no request is made and nothing is popped. When a command arrives, the block serves it without a reset.
- R7: If the block is busy, not receiving, with an empty queue, and either auto-stop is on or the master is disabled, it issues a STOP request.
- R8: If the block is enabled, in the middle of a receive command, the byte would be kept (R4), and `rx_full` is high, then `stall` is 1 and no request is made. Once `rx_full` falls, the next receive request follows.
- R9: While `master_en` is low, `stall` is 0. A transfer already in progress keeps taking commands until its STOP. Once the block is idle and disabled, no command is popped and no request is made.
- R10: When the block is idle and enabled, a START word opens a transfer. Any other word is popped and dropped without a request.
- R11: `busy` rises in the cycle a START request appears. It falls in the cycle after `eng_done` is sampled for a STOP request. After reset, `eng_req`, `busy`, `stall` and `eng_alt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_empty | input | 1 | Command queue is empty |
| cmd_head | input | 11 | Command word at the head of the queue |
| cmd_pop | output | 1 | Remove the head word this cycle |
| rx_full | input | 1 | Receive buffer cannot take another byte |
| master_en | input | 1 | Master enable |
| autostop_en | input | 1 | Close with a STOP when the queue runs dry |
| rx_discard_match | input | 1 | Received bytes are currently being dropped by the match logic |
| eng_done | input | 1 | Engine finished the current request |
| eng_req | output | 1 | Request pending for the engine |
| eng_op | output | 3 | Request kind: 1 START, 2 send, 3 receive, 4 STOP |
| eng_data | output | 8 | Address or data byte for START and send |
| eng_ack | output | 1 | Drive ACK (1) or NACK (0) after a received byte |
| eng_alt | output | 1 | Alternate timing set selected |
| rx_store | output | 1 | Store the received byte |
| stall | output | 1 | Hold the clock low before the next byte |
| busy | output | 1 | Transfer open between START and STOP |

## Verification
Errors inside the block show up at the engine port within one request. A receive counter that is off by one gives an extra or missing receive request. It also moves the NACK onto the wrong byte, so the ACK pattern of a short run is wrong before the closing STOP. A wrong busy or enable decision appears within a cycle of the queue running empty: the block stalls where a STOP belongs, or sends a STOP where it should stall. A timing select that is not held shows up as a wrong `eng_alt` on the first request after a START.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    localparam int OPC_W = 3;
    localparam int PAY_W = 8;
    localparam int CMD_W = OPC_W + PAY_W;

    typedef enum logic [OPC_W-1:0] {
        OPC_TX        = 3'd0,
        OPC_RX        = 3'd1,
        OPC_RXD       = 3'd2,
        OPC_START     = 3'd3,
        OPC_START_ALT = 3'd4,
        OPC_STOP      = 3'd5
    } opc_e;

    typedef enum logic [2:0] {
        EOP_NONE  = 3'd0,
        EOP_START = 3'd1,
        EOP_TX    = 3'd2,
        EOP_RX    = 3'd3,
        EOP_STOP  = 3'd4
    } eop_e;

    typedef enum logic {
        S_DEC  = 1'b0,
        S_WAIT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic             issue;
        eop_e             op;
        logic [PAY_W-1:0] data;
        logic             ack;
        logic             alt_set;
        logic             alt_val;
        logic             store;
        logic             pop;
        logic             load_rx;
        logic             stall;
    } act_t;

    function automatic logic is_rx(opc_e o);
        return (o == OPC_RX) || (o == OPC_RXD);
    endfunction

    function automatic logic is_start(opc_e o);
        return (o == OPC_START) || (o == OPC_START_ALT);
    endfunction

endpackage

// File: rtl/i2c_rx_tracker.sv
module i2c_rx_tracker #(
    parameter int CNT_W = i2c_cmd_pkg::PAY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    input  logic             load_disc,
    input  logic             step,
    output logic             active,
    output logic             last,
    output logic             disc
);
    localparam logic [CNT_W-1:0] ONE = 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            disc   <= 1'b0;
        end else if (load) begin
            active <= 1'b1;
            cnt    <= load_count;
            disc   <= load_disc;
        end else if (step) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - ONE;
        end
    end

    assign last = (cnt == '0);

    // R2: a byte completes only inside a receive run
    a_r2_step_live: assert property (@(posedge clk) disable iff (rst)
        step |-> active);
    // R2: a new receive word is taken only after the previous run ended
    a_r2_load_idle: assert property (@(posedge clk) disable iff (rst)
        load |-> !active);

endmodule

// File: rtl/i2c_cmd_decide.sv
module i2c_cmd_decide
    import i2c_cmd_pkg::*;
(
    input  logic             decide,
    input  logic             busy,
    input  logic             rx_active,
    input  logic             rx_last,
    input  logic             rx_disc_kind,
    input  logic             cmd_empty,
    input  logic [CMD_W-1:0] cmd_head,
    input  logic             rx_full,
    input  logic             master_en,
    input  logic             autostop_en,
    input  logic             rx_discard_match,
    output act_t             act
);
    opc_e             opc;
    logic [PAY_W-1:0] pay;
    logic             keep;

    assign opc  = opc_e'(cmd_head[CMD_W-1 -: OPC_W]);
    assign pay  = cmd_head[PAY_W-1:0];
    assign keep = !rx_disc_kind && !rx_discard_match;

    always_comb begin
        act = '0;
        if (decide) begin
            if (!busy) begin
                if (master_en && !cmd_empty) begin
                    act.pop = 1'b1;
                    if (is_start(opc)) begin
                        act.issue   = 1'b1;
                        act.op      = EOP_START;
                        act.data    = pay;
                        act.alt_set = 1'b1;
                        act.alt_val = (opc == OPC_START_ALT);
                    end
                end
            end else if (rx_active) begin
                if (master_en && keep && rx_full) begin
                    act.stall = 1'b1;
                end else begin
                    act.issue = 1'b1;
                    act.op    = EOP_RX;
                    act.store = keep;
                    act.ack   = !rx_last || (!cmd_empty && is_rx(opc));
                end
            end else if (cmd_empty) begin
                if (master_en && !autostop_en) begin
                    act.stall = 1'b1;
                end else begin
                    act.issue = 1'b1;
                    act.op    = EOP_STOP;
                end
            end else begin
                act.pop = 1'b1;
                case (opc)
                    OPC_TX: begin
                        act.issue = 1'b1;
                        act.op    = EOP_TX;
                        act.data  = pay;
                    end
                    OPC_RX, OPC_RXD: act.load_rx = 1'b1;
                    OPC_START, OPC_START_ALT: begin
                        act.issue   = 1'b1;
                        act.op      = EOP_START;
                        act.data    = pay;
                        act.alt_set = 1'b1;
                        act.alt_val = (opc == OPC_START_ALT);
                    end
                    OPC_STOP: begin
                        act.issue = 1'b1;
                        act.op    = EOP_STOP;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2c_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_empty,
    input  logic [CMD_W-1:0] cmd_head,
    output logic             cmd_pop,
    input  logic             rx_full,
    input  logic             master_en,
    input  logic             autostop_en,
    input  logic             rx_discard_match,
    input  logic             eng_done,
    output logic             eng_req,
    output logic [2:0]       eng_op,
    output logic [PAY_W-1:0] eng_data,
    output logic             eng_ack,
    output logic             eng_alt,
    output logic             rx_store,
    output logic             stall,
    output logic             busy
);
    seq_state_e state;
    eop_e       op_q;
    act_t       act;
    logic       rx_active, rx_last, rx_disc;
    logic       step;

    assign step = (state == S_WAIT) && eng_done && (op_q == EOP_RX);

    i2c_rx_tracker #(.CNT_W(PAY_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .load       (act.load_rx),
        .load_count (cmd_head[PAY_W-1:0]),
        .load_disc  (cmd_head[CMD_W-1 -: OPC_W] == OPC_RXD),
        .step       (step),
        .active     (rx_active),
        .last       (rx_last),
        .disc       (rx_disc)
    );

    i2c_cmd_decide u_dec (
        .decide           (state == S_DEC),
        .busy             (busy),
        .rx_active        (rx_active),
        .rx_last          (rx_last),
        .rx_disc_kind     (rx_disc),
        .cmd_empty        (cmd_empty),
        .cmd_head         (cmd_head),
        .rx_full          (rx_full),
        .master_en        (master_en),
        .autostop_en      (autostop_en),
        .rx_discard_match (rx_discard_match),
        .act              (act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_DEC;
            busy     <= 1'b0;
            eng_req  <= 1'b0;
            op_q     <= EOP_NONE;
            eng_data <= '0;
            eng_ack  <= 1'b0;
            eng_alt  <= 1'b0;
            rx_store <= 1'b0;
        end else begin
            case (state)
                S_DEC: if (act.issue) begin
                    eng_req  <= 1'b1;
                    op_q     <= act.op;
                    eng_data <= act.data;
                    eng_ack  <= act.ack;
                    rx_store <= act.store;
                    if (act.alt_set)         eng_alt <= act.alt_val;
                    if (act.op == EOP_START) busy    <= 1'b1;
                    state <= S_WAIT;
                end
                S_WAIT: if (eng_done) begin
                    eng_req <= 1'b0;
                    if (op_q == EOP_STOP) busy <= 1'b0;
                    state <= S_DEC;
                end
                default: state <= S_DEC;
            endcase
        end
    end

    assign eng_op  = op_q;
    assign cmd_pop = act.pop;
    assign stall   = act.stall;

    // R2: request fields hold until the engine answers
    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_data) && $stable(eng_ack));
    // R6: a stalled cycle neither requests nor consumes
    a_r6_stall_quiet: assert property (@(posedge clk) disable iff (rst)
        stall |-> !eng_req && !cmd_pop);
    // R9: no stall while disabled
    a_r9_no_stall_off: assert property (@(posedge clk) disable iff (rst)
        !master_en |-> !stall);
    // R3: ACK is only driven for receive requests
    a_r3_ack_rx_only: assert property (@(posedge clk) disable iff (rst)
        eng_req && (op_q != EOP_RX) |-> !eng_ack);
    // R11: busy opens with a START request
    a_r11_busy_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> eng_req && (op_q == EOP_START));
    // R11: busy closes right after a STOP completes
    a_r11_busy_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(eng_done) && ($past(op_q) == EOP_STOP));

endmodule

// File: tb/i2c_cmd_seq_bench.sv
`timescale 1ns/1ps
module i2c_cmd_seq_bench;

    localparam logic [2:0] C_TX = 3'd0, C_RX = 3'd1, C_RXD = 3'd2,
                           C_ST = 3'd3, C_STA = 3'd4, C_SP = 3'd5;
    localparam logic [2:0] O_ST = 3'd1, O_TX = 3'd2, O_RX = 3'd3, O_SP = 3'd4;
    localparam logic [10:0] PADC = 11'h0;
    localparam logic [13:0] PADE = 14'h0;

    typedef struct packed {
        logic [0:5][10:0] cmd;
        logic [2:0]       ncmd;
        logic [0:5][13:0] exp;
        logic [2:0]       nexp;
        logic             autostop;
        logic             rxfull;
        logic             dmatch;
        logic             fin_busy;
        logic             fin_stall;
    } vec_t;

    // expected entry: {op, data, ack, alt, store}
    localparam vec_t VECS [0:8] = '{
        '{ {{C_ST,8'hA0},{C_TX,8'h11},{C_RX,8'h01},{C_SP,8'h00},PADC,PADC}, 3'd4,
           {{O_ST,8'hA0,3'b000},{O_TX,8'h11,3'b000},{O_RX,8'h00,3'b101},
            {O_RX,8'h00,3'b001},{O_SP,8'h00,3'b000},PADE}, 3'd5, 1'b0,1'b0,1'b0,1'b0,1'b0 },
        '{ {{C_STA,8'h42},{C_RX,8'h00},{C_RXD,8'h00},{C_RX,8'h00},{C_SP,8'h00},PADC}, 3'd5,
           {{O_ST,8'h42,3'b010},{O_RX,8'h00,3'b111},{O_RX,8'h00,3'b110},
            {O_RX,8'h00,3'b011},{O_SP,8'h00,3'b010},PADE}, 3'd5, 1'b0,1'b0,1'b0,1'b0,1'b0 },
        '{ {{C_ST,8'h10},{C_TX,8'h22},PADC,PADC,PADC,PADC}, 3'd2,
           {{O_ST,8'h10,3'b000},{O_TX,8'h22,3'b000},{O_SP,8'h00,3'b000},PADE,PADE,PADE},
           3'd3, 1'b1,1'b0,1'b0,1'b0,1'b0 },
        '{ {{C_STA,8'h30},{C_TX,8'h01},{C_ST,8'h31},{C_RX,8'h00},{C_SP,8'h00},PADC}, 3'd5,
           {{O_ST,8'h30,3'b010},{O_TX,8'h01,3'b010},{O_ST,8'h31,3'b000},
            {O_RX,8'h00,3'b001},{O_SP,8'h00,3'b000},PADE}, 3'd5, 1'b0,1'b0,1'b0,1'b0,1'b0 },
        '{ {{C_ST,8'h60},{C_RX,8'h00},PADC,PADC,PADC,PADC}, 3'd2,
           {{O_ST,8'h60,3'b000},{O_RX,8'h00,3'b001},{O_SP,8'h00,3'b000},PADE,PADE,PADE},
           3'd3, 1'b1,1'b0,1'b0,1'b0,1'b0 },
        '{ {{C_TX,8'h99},{C_SP,8'h00},{C_ST,8'h12},{C_SP,8'h00},PADC,PADC}, 3'd4,
           {{O_ST,8'h12,3'b000},{O_SP,8'h00,3'b000},PADE,PADE,PADE,PADE},
           3'd2, 1'b0,1'b0,1'b0,1'b0,1'b0 },
        '{ {{C_ST,8'h11},{3'd6,8'hEE},{C_TX,8'h22},{C_SP,8'h00},PADC,PADC}, 3'd4,
           {{O_ST,8'h11,3'b000},{O_TX,8'h22,3'b000},{O_SP,8'h00,3'b000},PADE,PADE,PADE},
           3'd3, 1'b0,1'b0,1'b0,1'b0,1'b0 },
        '{ {{C_ST,8'h20},{C_RXD,8'h00},{C_SP,8'h00},PADC,PADC,PADC}, 3'd3,
           {{O_ST,8'h20,3'b000},{O_RX,8'h00,3'b000},{O_SP,8'h00,3'b000},PADE,PADE,PADE},
           3'd3, 1'b0,1'b1,1'b0,1'b0,1'b0 },
        '{ {{C_ST,8'h21},{C_RX,8'h01},{C_SP,8'h00},PADC,PADC,PADC}, 3'd3,
           {{O_ST,8'h21,3'b000},{O_RX,8'h00,3'b100},{O_RX,8'h00,3'b000},
            {O_SP,8'h00,3'b000},PADE,PADE}, 3'd4, 1'b0,1'b1,1'b1,1'b0,1'b0 }
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_empty, cmd_pop;
    logic [10:0] cmd_head;
    logic        rx_full = 1'b0, master_en = 1'b1, autostop_en = 1'b0, rx_discard_match = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_req, eng_ack, eng_alt, rx_store, stall, busy;
    logic [2:0]  eng_op;
    logic [7:0]  eng_data;

    logic [10:0] fq [0:15];
    int          f_rd = 0, f_wr = 0;
    logic [13:0] log_q [0:31];
    int          log_n = 0;
    int          ecnt = 0;
    int          n_tests = 0, n_fail = 0;

    always #10 clk = ~clk;

    assign cmd_empty = (f_rd == f_wr);
    assign cmd_head  = fq[f_rd % 16];

    always @(posedge clk) begin
        if (rst)          f_rd <= 0;
        else if (cmd_pop) f_rd <= f_rd + 1;
    end

    i2c_cmd_seq u_i2c_cmd_seq (
        .clk(clk), .rst(rst), .cmd_empty(cmd_empty), .cmd_head(cmd_head), .cmd_pop(cmd_pop),
        .rx_full(rx_full), .master_en(master_en), .autostop_en(autostop_en),
        .rx_discard_match(rx_discard_match), .eng_done(eng_done), .eng_req(eng_req),
        .eng_op(eng_op), .eng_data(eng_data), .eng_ack(eng_ack), .eng_alt(eng_alt),
        .rx_store(rx_store), .stall(stall), .busy(busy)
    );

    // engine model: answers each request two cycles after it appears
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                eng_done = 1'b0;
                ecnt = 0;
            end else if (eng_done) begin
                eng_done = 1'b0;
            end else if (eng_req) begin
                ecnt++;
                if (ecnt >= 2) begin
                    eng_done = 1'b1;
                    ecnt = 0;
                    if (log_n < 32) log_q[log_n] = {eng_op, eng_data, eng_ack, eng_alt, rx_store};
                    log_n++;
                end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(logic [10:0] w);
        fq[f_wr % 16] = w;
        f_wr++;
    endtask

    task automatic do_reset(logic as, logic rf, logic dm);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        f_wr = 0;
        log_n = 0;
        autostop_en = as;
        rx_full = rf;
        rx_discard_match = dm;
        master_en = 1'b1;
    endtask

    task automatic release_rst();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_log(int n);
        for (int k = 0; k < 3000 && log_n < n; k++) @(negedge clk);
    endtask

    function automatic string vtag(int v);
        case (v)
            0: return "R3 nack before stop";
            1: return "R3 R4 R5 receive chain";
            2: return "R7 autostop";
            3: return "R5 timing switch";
            4: return "R7 R3 nack on empty";
            5: return "R10 idle drop";
            6: return "R1 reserved opcode";
            7: return "R8 discard no stall";
            default: return "R4 R8 match discard";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R11 watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) fq[i] = '0;

        // reset state
        do_reset(1'b0, 1'b0, 1'b0);
        chk("R11 reset eng_req", eng_req, 0);
        chk("R11 reset busy", busy, 0);
        chk("R11 reset stall", stall, 0);
        chk("R11 reset eng_alt", eng_alt, 0);

        // table of command sequences
        for (int v = 0; v < 9; v++) begin
            vec_t t;
            t = VECS[v];
            do_reset(t.autostop, t.rxfull, t.dmatch);
            for (int i = 0; i < int'(t.ncmd); i++) push(t.cmd[i]);
            release_rst();
            wait_log(int'(t.nexp));
            repeat (10) @(negedge clk);
            chk({vtag(v), " R2 request count"}, log_n, t.nexp);
            for (int i = 0; i < int'(t.nexp); i++) chk(vtag(v), log_q[i], t.exp[i]);
            chk({vtag(v), " R11 final busy"}, busy, t.fin_busy);
            chk({vtag(v), " final stall"}, stall, t.fin_stall);
        end

        // R6 stall on empty queue, then resume; R9 disable closes the transfer
        do_reset(1'b0, 1'b0, 1'b0);
        push({C_ST, 8'h50});
        push({C_TX, 8'h77});
        release_rst();
        wait_log(2);
        repeat (6) @(negedge clk);
        chk("R6 stall high", stall, 1);
        chk("R6 no request while stalled", eng_req, 0);
        chk("R6 busy while stalled", busy, 1);
        chk("R6 nothing extra sent", log_n, 2);
        push({C_TX, 8'h33});
        wait_log(3);
        chk("R6 resume byte", log_q[2], {O_TX, 8'h33, 3'b000});
        repeat (4) @(negedge clk);
        master_en = 1'b0;
        @(negedge clk);
        chk("R9 no stall when disabled", stall, 0);
        wait_log(4);
        repeat (4) @(negedge clk);
        chk("R9 auto stop on disable", log_q[3], {O_SP, 8'h00, 3'b000});
        chk("R11 busy cleared after stop", busy, 0);
        push({C_ST, 8'h70});
        repeat (10) @(negedge clk);
        chk("R9 idle disabled no pop", f_wr - f_rd, 1);
        chk("R9 idle disabled no request", log_n, 4);
        master_en = 1'b1;
        wait_log(5);
        chk("R10 start after enable", log_q[4], {O_ST, 8'h70, 3'b000});

        // R8 receive stall while buffer full, resume when it drains
        do_reset(1'b0, 1'b1, 1'b0);
        push({C_ST, 8'h24});
        push({C_RX, 8'h01});
        push({C_SP, 8'h00});
        release_rst();
        wait_log(1);
        repeat (8) @(negedge clk);
        chk("R8 stall on full buffer", stall, 1);
        chk("R8 no receive while full", log_n, 1);
        rx_full = 1'b0;
        wait_log(4);
        chk("R8 first byte after drain", log_q[1], {O_RX, 8'h00, 3'b101});
        chk("R3 last byte nack", log_q[2], {O_RX, 8'h00, 3'b001});
        chk("R8 closing stop", log_q[3], {O_SP, 8'h00, 3'b000});

        // R9 disable removes a receive stall and ends with an automatic stop
        do_reset(1'b0, 1'b1, 1'b0);
        push({C_ST, 8'h40});
        push({C_RX, 8'h00});
        release_rst();
        wait_log(1);
        repeat (8) @(negedge clk);
        chk("R8 stall before disable", stall, 1);
        master_en = 1'b0;
        @(negedge clk);
        chk("R9 stall drops on disable", stall, 0);
        wait_log(3);
        chk("R9 receive proceeds", log_q[1], {O_RX, 8'h00, 3'b001});
        chk("R9 stop follows", log_q[2], {O_SP, 8'h00, 3'b000});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule